// File: doc/BRIEF.md
# Double-Edge Pin Register Cell

This cell sits between a group of pad signals and the core logic. It samples incoming pad data on both edges of a receive clock. It also launches outgoing data and the matching drive enable on both edges of a transmit clock. The core gets one value per edge, so it can run at the pin's full two-edge rate on a single-edge clock.

The receive side holds two registers, one loaded on the rising edge and one on the falling edge of `in_clk`. The transmit side holds two such register pairs: one pair for data and one for drive enable. A multiplexer steered by the level of `out_clk` selects which register of each pair reaches the pad. Each side has its own clock and clock enable. One synchronous set and one synchronous reset act on all six registers, and reset wins over set.

The pad is modelled as three separate signals: input data, output data and output enable. Every bit of every bus is an independent pin of width `WIDTH`. Data moves on every enabled edge, with no handshake and no back-pressure: a clock enable is the only way to pause a side.

Top module: `ddr_io_cell`

## Requirements
- R1: On a rising `in_clk` edge with `in_ce` high and neither `ctl_rst` nor `ctl_set` high, `rx_rise` takes the value of `pad_i`.
- R2: On a falling `in_clk` edge with `in_ce` high and neither `ctl_rst` nor `ctl_set` high, `rx_fall` takes the value of `pad_i`.
- R3: `pad_o` shows the value of `tx_rise` loaded at the last enabled rising `out_clk` edge while `out_clk` is high. It shows the value of `tx_fall` loaded at the last enabled falling edge while `out_clk` is low.
- R4: `pad_oe` follows `oe_rise` and `oe_fall` by clock phase in the same way as R3, bit by bit. A low bit means that pin is not driven, and its `pad_o` bit carries no meaning.
- R5: With `in_ce` low, the input registers keep their values, whatever the output side or `pad_i` does.
- R6: With `out_ce` low, the data and enable registers keep their values, so `pad_o` and `pad_oe` repeat the last pair, whatever the input side does.
- R7: With `ctl_rst` high, each of the six registers clears to all zeros on its own clock edge. This happens regardless of clock enable and of `ctl_set`.
- R8: With `ctl_set` high and `ctl_rst` low, each of the six registers loads all ones on its own clock edge, regardless of clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Receive clock; both edges used |
| in_ce | input | 1 | Receive clock enable |
| out_clk | input | 1 | Transmit clock; both edges used, level selects pad source |
| out_ce | input | 1 | Transmit clock enable |
| ctl_set | input | 1 | Synchronous set, all registers |
| ctl_rst | input | 1 | Synchronous reset, all registers, priority over set |
| pad_i | input | WIDTH | Data arriving from the pins |
| rx_rise | output | WIDTH | Value captured on rising `in_clk` |
| rx_fall | output | WIDTH | Value captured on falling `in_clk` |
| tx_rise | input | WIDTH | Data for the high phase of `out_clk` |
| tx_fall | input | WIDTH | Data for the low phase of `out_clk` |
| oe_rise | input | WIDTH | Drive enable for the high phase |
| oe_fall | input | WIDTH | Drive enable for the low phase |
| pad_o | output | WIDTH | Data towards the pins |
| pad_oe | output | WIDTH | Per-pin drive enable, high drives |

## Verification
The bench builds the cell with `WIDTH` set to 4. Words can therefore mix driven and undriven pins, so the per-bit independence of the enable multiplexer becomes visible. The same width lets an all-ones set pattern be told apart from single-bit behaviour. Both sides share one bench clock, so captured pairs and launched pairs can be checked against the same edges. Independence of the two sides comes from holding one clock enable low while the other side keeps moving.

// File: rtl/ddr_io_pkg.sv
package ddr_io_pkg;
  // Which clock edge a storage element responds to.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/ddr_edge_reg.sv
module ddr_edge_reg
  import ddr_io_pkg::*;
#(
  parameter int    WIDTH = 1,
  parameter edge_e EDGE  = EDGE_RISE
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             rst,
  input  logic             set,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;
  localparam logic [WIDTH-1:0] ALL_ONE  = '1;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  // Reset outranks set; both ignore the clock enable.
  always_comb begin
    if (rst)      q_nxt = ALL_ZERO;
    else if (set) q_nxt = ALL_ONE;
    else if (ce)  q_nxt = d;
    else          q_nxt = q_r;
  end

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) q_r <= q_nxt;
    end else begin : g_fall
      always_ff @(negedge clk) q_r <= q_nxt;
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/ddr_in_path.sv
module ddr_in_path
  import ddr_io_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             rst,
  input  logic             set,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] q_rise,
  output logic [WIDTH-1:0] q_fall
);
  ddr_edge_reg #(.WIDTH(WIDTH), .EDGE(EDGE_RISE)) u_rise (
    .clk(clk), .ce(ce), .rst(rst), .set(set), .d(pin), .q(q_rise)
  );

  ddr_edge_reg #(.WIDTH(WIDTH), .EDGE(EDGE_FALL)) u_fall (
    .clk(clk), .ce(ce), .rst(rst), .set(set), .d(pin), .q(q_fall)
  );
endmodule

// File: rtl/ddr_out_path.sv
module ddr_out_path
  import ddr_io_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             rst,
  input  logic             set,
  input  logic [WIDTH-1:0] d_rise,
  input  logic [WIDTH-1:0] d_fall,
  output logic [WIDTH-1:0] pad
);
  logic [WIDTH-1:0] q_rise;
  logic [WIDTH-1:0] q_fall;

  ddr_edge_reg #(.WIDTH(WIDTH), .EDGE(EDGE_RISE)) u_rise (
    .clk(clk), .ce(ce), .rst(rst), .set(set), .d(d_rise), .q(q_rise)
  );

  ddr_edge_reg #(.WIDTH(WIDTH), .EDGE(EDGE_FALL)) u_fall (
    .clk(clk), .ce(ce), .rst(rst), .set(set), .d(d_fall), .q(q_fall)
  );

  // High phase shows the rising-edge register, low phase the falling one.
  assign pad = clk ? q_rise : q_fall;
endmodule

// File: rtl/ddr_io_cell.sv
module ddr_io_cell #(
  parameter int WIDTH = 1
) (
  input  logic             in_clk,
  input  logic             in_ce,
  input  logic             out_clk,
  input  logic             out_ce,
  input  logic             ctl_set,
  input  logic             ctl_rst,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] rx_rise,
  output logic [WIDTH-1:0] rx_fall,
  input  logic [WIDTH-1:0] tx_rise,
  input  logic [WIDTH-1:0] tx_fall,
  input  logic [WIDTH-1:0] oe_rise,
  input  logic [WIDTH-1:0] oe_fall,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe
);
  ddr_in_path #(.WIDTH(WIDTH)) u_rx (
    .clk(in_clk), .ce(in_ce), .rst(ctl_rst), .set(ctl_set),
    .pin(pad_i), .q_rise(rx_rise), .q_fall(rx_fall)
  );

  ddr_out_path #(.WIDTH(WIDTH)) u_tx_data (
    .clk(out_clk), .ce(out_ce), .rst(ctl_rst), .set(ctl_set),
    .d_rise(tx_rise), .d_fall(tx_fall), .pad(pad_o)
  );

  ddr_out_path #(.WIDTH(WIDTH)) u_tx_en (
    .clk(out_clk), .ce(out_ce), .rst(ctl_rst), .set(ctl_set),
    .d_rise(oe_rise), .d_fall(oe_fall), .pad(pad_oe)
  );
endmodule

// File: rtl/ddr_io_cell_chk.sv
module ddr_io_cell_chk #(
  parameter int WIDTH = 1
) (
  input logic             in_clk,
  input logic             in_ce,
  input logic             out_clk,
  input logic             out_ce,
  input logic             ctl_set,
  input logic             ctl_rst,
  input logic [WIDTH-1:0] pad_i,
  input logic [WIDTH-1:0] rx_rise,
  input logic [WIDTH-1:0] rx_fall,
  input logic [WIDTH-1:0] tx_rise,
  input logic [WIDTH-1:0] tx_fall,
  input logic [WIDTH-1:0] oe_rise,
  input logic [WIDTH-1:0] oe_fall,
  input logic [WIDTH-1:0] pad_o,
  input logic [WIDTH-1:0] pad_oe
);
  // Values offered at the last transmit edge of each kind, and whether that edge loaded them.
  logic [WIDTH-1:0] hi_tx, hi_oe, lo_tx, lo_oe;
  logic             hi_live, lo_live;

  always_ff @(posedge out_clk) begin
    hi_tx   <= tx_rise;
    hi_oe   <= oe_rise;
    hi_live <= out_ce && !ctl_set && !ctl_rst;
  end

  always_ff @(negedge out_clk) begin
    lo_tx   <= tx_fall;
    lo_oe   <= oe_fall;
    lo_live <= out_ce && !ctl_set && !ctl_rst;
  end

  assert_rx_rise_load_R1: assert property (@(posedge in_clk) disable iff (ctl_rst)
    (in_ce && !ctl_set) |=> (rx_rise == $past(pad_i)));

  assert_rx_fall_load_R2: assert property (@(negedge in_clk) disable iff (ctl_rst)
    (in_ce && !ctl_set) |=> (rx_fall == $past(pad_i)));

  assert_pad_high_phase_R3: assert property (@(negedge out_clk) disable iff (ctl_rst)
    hi_live |-> (pad_o == hi_tx));

  assert_pad_low_phase_R3: assert property (@(posedge out_clk) disable iff (ctl_rst)
    lo_live |-> (pad_o == lo_tx));

  assert_oe_high_phase_R4: assert property (@(negedge out_clk) disable iff (ctl_rst)
    hi_live |-> (pad_oe == hi_oe));

  assert_oe_low_phase_R4: assert property (@(posedge out_clk) disable iff (ctl_rst)
    lo_live |-> (pad_oe == lo_oe));

  assert_rx_hold_R5: assert property (@(posedge in_clk) disable iff (ctl_rst)
    (!in_ce && !ctl_set) |=> $stable(rx_rise));

  assert_rx_clear_R7: assert property (@(posedge in_clk)
    ctl_rst |=> (rx_rise == '0));

  assert_rx_fill_R8: assert property (@(posedge in_clk) disable iff (ctl_rst)
    ctl_set |=> (rx_rise == '1));
endmodule

bind ddr_io_cell ddr_io_cell_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ddr_io_cell_bench.sv
module ddr_io_cell_bench;
  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 8;

  // Each entry: {tx_rise, tx_fall, oe_rise, oe_fall, pin_rise, pin_fall}, W bits each.
  localparam logic [6*W-1:0] VEC [NVEC] = '{
    24'h5AF0C3, 24'hA5FF3C, 24'h0F0F96, 24'hF0F069,
    24'h3C0FAA, 24'hC3F055, 24'hFF8801, 24'h00F1FE
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         in_ce = 1'b1, out_ce = 1'b1;
  logic         ctl_set = 1'b1, ctl_rst = 1'b1;
  logic [W-1:0] pad_i = '0, tx_rise = '0, tx_fall = '0, oe_rise = '0, oe_fall = '0;
  logic [W-1:0] rx_rise, rx_fall, pad_o, pad_oe;

  int checks = 0;
  int fails  = 0;

  ddr_io_cell #(.WIDTH(W)) u_ddr_io_cell (
    .in_clk(clk), .in_ce(in_ce), .out_clk(clk), .out_ce(out_ce),
    .ctl_set(ctl_set), .ctl_rst(ctl_rst), .pad_i(pad_i),
    .rx_rise(rx_rise), .rx_fall(rx_fall),
    .tx_rise(tx_rise), .tx_fall(tx_fall), .oe_rise(oe_rise), .oe_fall(oe_fall),
    .pad_o(pad_o), .pad_oe(pad_oe)
  );

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Called with clk low; drives a pair, checks after the rising and the falling edge.
  task automatic step(input string tag,
                      input logic [W-1:0] tr, tf, er, ef, pr, pf,
                      input logic [W-1:0] xrr, xrf, xor_, xof, xer, xef);
    tx_rise = tr; tx_fall = tf; oe_rise = er; oe_fall = ef; pad_i = pr;
    @(posedge clk); #2;
    chk({tag, " rx_rise"}, rx_rise, xrr);
    chk({tag, " pad_o high"}, pad_o, xor_);
    chk({tag, " pad_oe high"}, pad_oe, xer);
    pad_i = pf;
    @(negedge clk); #2;
    chk({tag, " rx_fall"}, rx_fall, xrf);
    chk({tag, " pad_o low"}, pad_o, xof);
    chk({tag, " pad_oe low"}, pad_oe, xef);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R7: reset and set together, reset must win; all outputs zero in both phases.
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    chk("R7 reset rx_rise", rx_rise, '0);
    chk("R7 reset rx_fall", rx_fall, '0);
    chk("R7 reset pad_o low", pad_o, '0);
    chk("R7 reset pad_oe low", pad_oe, '0);
    @(posedge clk); #2;
    chk("R7 reset pad_o high", pad_o, '0);
    chk("R7 reset pad_oe high", pad_oe, '0);

    // R8: set alone with both enables low still fills every register.
    ctl_rst = 1'b0; in_ce = 1'b0; out_ce = 1'b0;
    @(negedge clk);
    @(posedge clk); #2;
    chk("R8 set rx_rise", rx_rise, '1);
    chk("R8 set rx_fall", rx_fall, '1);
    chk("R8 set pad_o high", pad_o, '1);
    chk("R8 set pad_oe high", pad_oe, '1);
    @(negedge clk); #2;
    chk("R8 set pad_o low", pad_o, '1);
    chk("R8 set pad_oe low", pad_oe, '1);

    // Table walk: R1 R2 R3 R4 across mixed data and enable patterns.
    ctl_set = 1'b0; in_ce = 1'b1; out_ce = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] f [6];
      for (int k = 0; k < 6; k++) f[k] = VEC[i][(6-k)*W-1 -: W];
      step("R1 R2 R3 R4 table", f[0], f[1], f[2], f[3], f[4], f[5],
           f[4], f[5], f[0], f[1], f[2], f[3]);
    end

    // R5: input side paused, output side keeps moving.
    in_ce = 1'b0;
    step("R5 rx hold", 4'h9, 4'h6, 4'hF, 4'hF, 4'h0, 4'h1,
         4'hF, 4'hE, 4'h9, 4'h6, 4'hF, 4'hF);

    // R6: output side paused, input side keeps moving.
    in_ce = 1'b1; out_ce = 1'b0;
    step("R6 tx hold", 4'h3, 4'hC, 4'h0, 4'h0, 4'h5, 4'hA,
         4'h5, 4'hA, 4'h9, 4'h6, 4'hF, 4'hF);

    // R7: reset with enables low and set high clears everything.
    in_ce = 1'b0; ctl_rst = 1'b1; ctl_set = 1'b1;
    step("R7 reset over set", 4'hE, 4'h7, 4'hF, 4'hF, 4'hB, 4'hD,
         4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);

    // R1 R2 R3 R4: normal operation resumes straight after reset.
    ctl_rst = 1'b0; ctl_set = 1'b0; in_ce = 1'b1; out_ce = 1'b1;
    step("R1 R2 R3 R4 resume", 4'h8, 4'h1, 4'hC, 4'h3, 4'h7, 4'h2,
         4'h7, 4'h2, 4'h8, 4'h1, 4'hC, 4'h3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule